// File: doc/BRIEF.md
# Prescaled Timer-Counter with Buffered High Byte

This peripheral keeps a 16-bit count that advances either once per instruction-cycle tick or on a chosen edge of an external input. That input passes through a two-stage synchronizer before any edge is detected. The counter can run as an 8-bit counter, with the upper byte frozen, or as a full 16-bit counter. An optional divide-by-2^(n+1) prescaler can sit in front of it. The counter stops while the run bit is clear or the sleep input is high. Whenever the count wraps to zero it raises a sticky overflow flag. The flag drives an interrupt request through a mask bit.

Software uses a byte-wide register bus with four addresses. Software never accesses the counter's upper byte directly. It goes through a holding buffer, which is filled from the live upper byte when the low byte is read. In 16-bit mode, the buffer is copied into the live upper byte when the low byte is written. This makes 16-bit reads and writes atomic. Every write to the low byte clears the prescaler count. It also stops increments for the next two instruction-cycle ticks.

Top module: `tmr_unit`

## Requirements
- R1: After reset the registers read as follows. Control (address 2) reads FFh, the high buffer (address 1) reads 00h, the low byte (address 0) reads 00h and the interrupt register (address 3) reads 00h. The overflow flag and the irq output are low.
- R2: The control register layout is: bit7 run, bit6 eight-bit mode, bit5 external source, bit4 falling edge, bit3 prescaler bypass, bits2:0 ratio. With the internal source and the prescaler bypassed, each cycle with tick_en high advances the count by one, and the new value is readable in the next cycle.
- R3: With the external source selected, the count advances once per rising edge of ext_in when bit4 is 0, or once per falling edge when bit4 is 1. The new value is readable 3 cycles after ext_in changes. tick_en does not advance the count in this mode.
- R4: With bit3 clear, the count advances once every 2^(ratio+1) source events. The ratio values 0 to 7 give divide-by 2 to 256.
- R5: A low-byte write clears the prescaler count. It leaves the control register unchanged.
- R6: After a low-byte write, the source events in the next two cycles that have tick_en high are discarded.
- R7: In 8-bit mode the low byte wraps from FFh to 00h and sets the overflow flag. The high byte of the count never changes, and a low-byte write leaves it alone.
- R8: In 16-bit mode the count wraps from FFFFh to 0000h and sets the overflow flag.
- R9: The overflow flag is read as bit0 of address 3. It stays set until software writes address 3 with bit0 = 1. Bit1 of address 3 is the interrupt enable. irq is high only while both the flag and the enable are set.
- R10: A read of address 0 copies the live high byte into the high buffer. A read of address 1 returns the buffer and never the live high byte.
- R11: A write to address 1 updates only the buffer. In 16-bit mode, a write to address 0 loads the live high byte from the buffer in the same cycle.
- R12: The count does not change while sleep_in is high or while the run bit is 0.
- R13: rd_data is 00h while rd_en is low. With rd_en high, rd_data shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register address: 0 low byte, 1 high buffer, 2 control, 3 interrupt |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| ext_in | input | 1 | External count input, asynchronous |
| tick_en | input | 1 | Instruction-cycle tick |
| sleep_in | input | 1 | Sleep, halts counting |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |

## Verification
Results are due at fixed latencies:
- A tick or a register write takes effect at the next rising edge.
- An external edge shows in the count on the third rising edge after the input changes.
- rd_data and irq follow their inputs and state in the same cycle.

The bench drives inputs on the falling edge and compares shortly after it, so each sample already includes the register updates of the edge before. A behavioural model steps once per rising edge and is compared with rd_data, ovf_flag and irq in every cycle. The directed checks sample the synchronizer latency cycle by cycle, one cycle before and on the cycle the new count is due.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DATA_W  = 8;
  localparam int PRE_W   = 8;
  localparam int RATIO_W = 3;
  localparam int CNT_W   = 2 * DATA_W;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_IRQ  = 2'd3
  } tmr_sel_e;

  typedef struct packed {
    logic               run;
    logic               eight_bit;
    logic               ext_src;
    logic               fall_edge;
    logic               bypass;
    logic [RATIO_W-1:0] ratio;
  } tmr_ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_RESET = '1;

  // Prescaler terminal test: low (ratio+1) bits all ones before the step
  function automatic logic presc_hit(input logic [PRE_W-1:0] pc,
                                     input logic [RATIO_W-1:0] r);
    logic [PRE_W:0] span;
    span = ({{PRE_W{1'b0}}, 1'b1} << (r + 1)) - 1'b1;
    return &(pc | ~span[PRE_W-1:0]);
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c,
                                                  input logic eight);
    logic [CNT_W-1:0] n;
    if (eight) n = {c[CNT_W-1:DATA_W], c[DATA_W-1:0] + 1'b1};
    else       n = c + 1'b1;
    return n;
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] c, input logic eight);
    return eight ? (&c[DATA_W-1:0]) : (&c);
  endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic edge_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  logic rise_w, fall_w;
  assign rise_w     =  chain_q[STAGES-1] & ~prev_q;
  assign fall_w     = ~chain_q[STAGES-1] &  prev_q;
  assign edge_pulse = fall_sel ? fall_w : rise_w;
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               pulse_in,
  output logic               pulse_out,
  output logic [PRE_W-1:0]   pcnt
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   pcnt <= '0;
    else if (clr)                 pcnt <= '0;
    else if (pulse_in && !bypass) pcnt <= pcnt + 1'b1;

  assign pulse_out = pulse_in & (bypass | presc_hit(pcnt, ratio));
endmodule

// File: rtl/tmr_hold.sv
`timescale 1ns/1ps
module tmr_hold #(
  parameter int HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_TICKS);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  left_q <= '0;
    else if (start)              left_q <= HOLD_INIT;
    else if (tick && left_q != 0) left_q <= left_q - 1'b1;

  assign busy = (left_q != '0);
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_in,
  input  logic              tick_en,
  input  logic              sleep_in,
  output logic              ovf_flag,
  output logic              irq
);
  tmr_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] hbuf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ien_q;
  logic              flag_q;

  // named internal events
  logic wr_lo, wr_hi, wr_ctrl, wr_irq, rd_lo;
  logic ext_edge, src_pulse, gated, bump, wrap, hold_busy, flag_clr;
  logic run_w, eight_w;
  logic [PRE_W-1:0] pcnt;

  assign wr_lo   = wr_en && (reg_sel == SEL_LO);
  assign wr_hi   = wr_en && (reg_sel == SEL_HI);
  assign wr_ctrl = wr_en && (reg_sel == SEL_CTRL);
  assign wr_irq  = wr_en && (reg_sel == SEL_IRQ);
  assign rd_lo   = rd_en && (reg_sel == SEL_LO);
  assign run_w   = ctrl_q.run;
  assign eight_w = ctrl_q.eight_bit;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in),
    .fall_sel(ctrl_q.fall_edge), .edge_pulse(ext_edge)
  );

  tmr_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(wr_lo), .tick(tick_en), .busy(hold_busy)
  );

  assign src_pulse = ctrl_q.ext_src ? ext_edge : tick_en;
  assign gated     = src_pulse && ctrl_q.run && !sleep_in && !hold_busy && !wr_lo;

  tmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_lo), .bypass(ctrl_q.bypass),
    .ratio(ctrl_q.ratio), .pulse_in(gated), .pulse_out(bump), .pcnt(pcnt)
  );

  assign wrap     = bump && at_top(cnt_q, ctrl_q.eight_bit);
  assign flag_clr = wr_irq && wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else if (wr_lo)
      cnt_q <= {(ctrl_q.eight_bit ? cnt_q[CNT_W-1:DATA_W] : hbuf_q), wr_data};
    else if (bump)
      cnt_q <= count_step(cnt_q, ctrl_q.eight_bit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     hbuf_q <= '0;
    else if (wr_hi) hbuf_q <= wr_data;
    else if (rd_lo) hbuf_q <= cnt_q[CNT_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= tmr_ctrl_t'(CTRL_RESET);
    else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ien_q <= 1'b0;
    else if (wr_irq) ien_q <= wr_data[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (tmr_sel_e'(reg_sel))
        SEL_LO:   rd_data = cnt_q[DATA_W-1:0];
        SEL_HI:   rd_data = hbuf_q;
        SEL_CTRL: rd_data = ctrl_q;
        SEL_IRQ:  rd_data = {{(DATA_W-2){1'b0}}, ien_q, flag_q};
      endcase
    end
  end

  assign ovf_flag = flag_q;
  assign irq      = flag_q & ien_q;
endmodule

// File: rtl/tmr_unit_chk.sv
`timescale 1ns/1ps
module tmr_unit_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_lo,
  input logic             flag_clr,
  input logic             sleep_in,
  input logic             run_w,
  input logic             eight_w,
  input logic             hold_busy,
  input logic             bump,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PRE_W-1:0] pcnt,
  input logic             ovf_flag,
  input logic             irq,
  input logic             ien_q
);
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy && !wr_lo) |=> $stable(cnt_q)); // R6
  AST_HOLD_NO_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |-> !bump); // R6
  AST_SLEEP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_in || !run_w) && !wr_lo) |=> $stable(cnt_q)); // R12
  AST_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    eight_w |=> $stable(cnt_q[CNT_W-1:DATA_W])); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !wr_lo && !eight_w) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (pcnt == '0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R9
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq); // R9
endmodule

bind tmr_unit tmr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .flag_clr(flag_clr),
  .sleep_in(sleep_in), .run_w(run_w), .eight_w(eight_w),
  .hold_busy(hold_busy), .bump(bump), .cnt_q(cnt_q), .pcnt(pcnt),
  .ovf_flag(ovf_flag), .irq(irq), .ien_q(ien_q)
);

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb;
  logic       clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic       wr_en = 0, rd_en = 0, ext_in = 0, tick_en = 0, sleep_in = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       ovf_flag, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  tmr_unit u_dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .ext_in(ext_in),
    .tick_en(tick_en), .sleep_in(sleep_in), .ovf_flag(ovf_flag), .irq(irq));

  // ---------------- behavioural reference ----------------
  int         m_cnt, m_hbuf, m_pc, m_hold;
  logic [7:0] m_ctrl;
  bit         m_ien, m_flag;
  bit         hist[$];

  task automatic model_reset();
    m_cnt = 0; m_hbuf = 0; m_pc = 0; m_hold = 0; m_ctrl = 8'hFF;
    m_ien = 0; m_flag = 0; hist = '{0, 0, 0};
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit ev, ovf, fire;
      int old_cnt, old_hbuf, lo;
      ev = m_ctrl[4] ? (!hist[1] && hist[2]) : (hist[1] && !hist[2]);
      hist.push_front(ext_in); void'(hist.pop_back());
      if (!m_ctrl[5]) ev = tick_en;
      old_cnt = m_cnt; old_hbuf = m_hbuf; ovf = 0;
      if (wr_en && reg_sel == 0) begin
        m_cnt = m_ctrl[6] ? ((old_cnt & 32'hFF00) | wr_data) : (old_hbuf * 256 + wr_data);
        m_pc = 0; m_hold = 2;
      end else if (m_hold > 0) begin
        if (tick_en) m_hold--;
      end else if (ev && m_ctrl[7] && !sleep_in) begin
        fire = m_ctrl[3];
        if (!m_ctrl[3]) begin
          fire = ((m_pc + 1) % (1 << (m_ctrl[2:0] + 1))) == 0;
          m_pc = (m_pc + 1) % 256;
        end
        if (fire) begin
          if (m_ctrl[6]) begin
            lo = (old_cnt % 256) + 1;
            ovf = (lo == 256);
            m_cnt = (old_cnt & 32'hFF00) | (lo % 256);
          end else begin
            ovf = (old_cnt == 65535);
            m_cnt = (old_cnt + 1) % 65536;
          end
        end
      end
      if (wr_en && reg_sel == 1) m_hbuf = wr_data;
      else if (rd_en && reg_sel == 0) m_hbuf = old_cnt / 256;
      if (wr_en && reg_sel == 2) m_ctrl = wr_data;
      if (wr_en && reg_sel == 3) m_ien = wr_data[1];
      if (ovf) m_flag = 1;
      else if (wr_en && reg_sel == 3 && wr_data[0]) m_flag = 0;
    end
  end

  function automatic int model_rd();
    if (!rd_en) return 0;
    case (reg_sel)
      2'd0: return m_cnt % 256;
      2'd1: return m_hbuf;
      2'd2: return m_ctrl;
      default: return {m_ien, m_flag};
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      n_chk++;
      if (rd_data !== 8'(model_rd()) || ovf_flag !== m_flag || irq !== (m_flag && m_ien)) begin
        n_bad++;
        $display("FAIL %s model: rd=%h/%h flag=%b/%b irq=%b/%b", cur_req,
                 rd_data, model_rd(), ovf_flag, m_flag, irq, m_flag && m_ien);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input int exp, input string req);
    reg_sel = s; rd_en = 1; #2;
    chk(req, rd_data, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1; repeat (n) @(negedge clk); tick_en = 0;
  endtask

  task automatic ext_pulse();
    ext_in = 1; repeat (3) @(negedge clk);
    ext_in = 0; repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    #2; chk("R1 flag", ovf_flag, 0); chk("R1 irq", irq, 0); chk("R13 idle rd", rd_data, 0);
    @(negedge clk);
    rd_chk(2, 8'hFF, "R1 ctrl"); rd_chk(1, 0, "R1 hbuf");
    rd_chk(0, 0, "R1 lo");       rd_chk(3, 0, "R1 irq reg");

    // R2 / R6 internal count with hold
    cur_req = "R6";
    wr(2, 8'h88); wr(1, 8'h00); wr(0, 8'h00);
    ticks(5); rd_chk(0, 3, "R6 two ticks dropped");
    cur_req = "R2";
    ticks(4); rd_chk(0, 7, "R2 one per tick");

    // R7 8-bit overflow, high byte held
    cur_req = "R7";
    wr(1, 8'h5A); wr(0, 8'hFD); wr(2, 8'hC8);
    ticks(5);
    #2; chk("R7 flag set", ovf_flag, 1); chk("R9 masked irq", irq, 0);
    @(negedge clk);
    rd_chk(0, 8'h00, "R7 low wrapped"); rd_chk(1, 8'h5A, "R7 high held");
    wr(0, 8'h40); rd_chk(0, 8'h40, "R7 low write"); rd_chk(1, 8'h5A, "R7 write keeps high");

    // R9 flag and mask
    cur_req = "R9";
    wr(3, 8'h02); #2; chk("R9 irq enabled", irq, 1);
    repeat (3) @(negedge clk); #2; chk("R9 sticky", ovf_flag, 1);
    @(negedge clk);
    wr(3, 8'h03); #2; chk("R9 cleared", ovf_flag, 0); chk("R9 irq low", irq, 0);
    @(negedge clk);
    rd_chk(3, 8'h02, "R9 reg");

    // R8 16-bit overflow
    cur_req = "R8";
    wr(2, 8'h88); wr(1, 8'hFF); wr(0, 8'hFE);
    ticks(4);
    rd_chk(0, 0, "R8 low"); rd_chk(1, 0, "R8 high latched zero");
    #2; chk("R8 flag", ovf_flag, 1); @(negedge clk);
    wr(3, 8'h01);

    // R10 / R11 buffered high byte
    cur_req = "R11";
    wr(1, 8'h34); wr(0, 8'h10);
    wr(1, 8'h77); rd_chk(1, 8'h77, "R11 buffer only");
    cur_req = "R10";
    rd_chk(0, 8'h10, "R10 low"); rd_chk(1, 8'h34, "R10 latched high");

    // R4 prescaler ratios
    cur_req = "R4";
    wr(1, 0); wr(2, 8'h81); wr(0, 0); ticks(14); rd_chk(0, 3, "R4 div4");
    wr(2, 8'h80); wr(0, 0); ticks(12); rd_chk(0, 5, "R4 div2");
    wr(2, 8'h87); wr(0, 0); ticks(514); rd_chk(0, 2, "R4 div256");

    // R5 prescaler cleared by counter write
    cur_req = "R5";
    wr(2, 8'h82); wr(0, 0); ticks(7); rd_chk(0, 0, "R5 partial");
    wr(0, 0); ticks(9); rd_chk(0, 0, "R5 cleared");
    ticks(1); rd_chk(0, 1, "R5 eighth event"); rd_chk(2, 8'h82, "R5 assignment kept");

    // R3 external edges and latency
    cur_req = "R3";
    wr(2, 8'hA8); wr(0, 0); ticks(2);
    reg_sel = 0; rd_en = 1; ext_in = 1;
    @(negedge clk); #2; chk("R3 lat1", rd_data, 0);
    @(negedge clk); #2; chk("R3 lat2", rd_data, 0);
    @(negedge clk); #2; chk("R3 lat3", rd_data, 1);
    @(negedge clk); rd_en = 0; ext_in = 0; repeat (3) @(negedge clk);
    ext_pulse(); ext_pulse(); rd_chk(0, 3, "R3 rising");
    ticks(5); rd_chk(0, 3, "R3 tick ignored");
    wr(2, 8'hB8); wr(0, 0); ticks(2);
    ext_pulse(); ext_pulse(); rd_chk(0, 2, "R3 falling");

    // R12 sleep and run
    cur_req = "R12";
    wr(2, 8'h88); wr(0, 0); ticks(2);
    sleep_in = 1; ticks(10); sleep_in = 0; rd_chk(0, 0, "R12 sleep");
    wr(2, 8'h08); ticks(10); rd_chk(0, 0, "R12 run off");
    wr(2, 8'h88); ticks(3); rd_chk(0, 3, "R12 resume");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule